// File: doc/BRIEF.md
# Ones'-Complement Checksum Unit

This block checks that a stored program image is intact. At system start, software or a boot sequencer streams the image through it one byte per cycle. The block computes a checksum over the stream and compares the result with a reference value that was stored alongside the image. When the stream ends, it raises a one-cycle completion pulse and a mismatch flag.

Two checksum modes can be selected at run time.

- **Plain mode** keeps a single running sum of the bytes.
- **Fletcher mode** keeps two running sums:
  - The first sum accumulates the data bytes.
  - The second sum accumulates each updated value of the first.

Every addition in both modes is a ones'-complement addition. Any carry out of the top bit is added back into the lowest bit instead of being dropped.

A start pulse clears the sums and captures the mode for the whole stream. The beat that carries the end marker finishes the computation.

Top module: `ocsum_unit`

## Requirements
- R1: After reset, `done` and `mismatch` are low and `sum_out` is zero.
- R2: In plain mode (`mode_sel` = 0 at start), `sum_out[DATA_W-1:0]` is the ones'-complement sum of all accepted bytes and `sum_out[2*DATA_W-1:DATA_W]` is zero.
- R3: Every addition wraps its carry-out back into bit 0. For example, 0xFF plus 0x01 gives 0x01, and 0x80 plus 0x80 gives 0x01. A sum is zero only when both addends are zero.
- R4: In Fletcher mode (`mode_sel` = 1 at start), each accepted byte d updates the low sum as lo = lo + d, then the high sum as hi = hi + lo (using the new lo). `sum_out` is {hi, lo}, with hi in the upper DATA_W bits.
- R5: A `start` pulse clears both running sums to zero, so results do not depend on any earlier stream.
- R6: `done` rises for exactly one cycle, in the cycle after the beat with `in_valid` and `in_last` both high. `sum_out` and `mismatch` update in that same cycle and hold until the next completion.
- R7: `mismatch` is high exactly when the final checksum differs from `ref_sum` as sampled on the last beat.
- R8: The mode is taken from `mode_sel` at `start`. Changes to `mode_sel` during the stream have no effect.
- R9: Cycles with `in_valid` low leave the sums unchanged and do not end the stream, even if `in_last` or `in_byte` toggle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Pulse that clears the sums and captures the mode |
| mode_sel | input | 1 | 0 selects the plain sum, 1 selects Fletcher |
| in_valid | input | 1 | Byte on `in_byte` is accepted this cycle |
| in_byte | input | DATA_W | Stream data |
| in_last | input | 1 | Marks the final byte, qualified by `in_valid` |
| ref_sum | input | 2*DATA_W | Stored reference, sampled on the last beat |
| done | output | 1 | One-cycle completion pulse |
| mismatch | output | 1 | Final checksum differs from the reference |
| sum_out | output | 2*DATA_W | Final checksum, held until the next completion |

## Verification
The assertions rely on three assumptions about the inputs:
- `start` is never high in the same cycle as `in_valid`.
- Every stream is opened by its own `start` pulse.
- A stream carries at least one byte, so two completion beats never fall in adjacent cycles.

The stimulus keeps to these rules by construction. It pulses `start`, streams one or more bytes, and then leaves an idle cycle before the next `start`. Within those rules, the stimulus does the following:
- It toggles `mode_sel` mid-stream.
- It inserts bubbles that carry a raised `in_last` and garbage data.
- It drives a wrong `ref_sum` outside the last beat.

// File: rtl/ocsum_pkg.sv
package ocsum_pkg;
  typedef enum logic {
    MODE_SUM      = 1'b0,
    MODE_FLETCHER = 1'b1
  } ocsum_mode_e;
endpackage

// File: rtl/ocsum_add.sv
// Ones'-complement adder: the carry out of the top bit is folded into bit 0.
module ocsum_add #(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);
  logic [DATA_W:0] raw;

  always_comb begin
    raw = {1'b0, a} + {1'b0, b};
    // Low part is at most 2^W-2 when the carry is set, so one fold suffices.
    y   = raw[DATA_W-1:0] + {{(DATA_W-1){1'b0}}, raw[DATA_W]};
  end

  always_comb begin
    if (!$isunknown({a, b, y})) begin
      AST_ZERO_ONLY_FROM_ZERO: assert ((y != '0) || ((a == '0) && (b == '0))); // R3
    end
  end
endmodule

// File: rtl/ocsum_core.sv
// Running sums with mode capture.
module ocsum_core
  import ocsum_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              mode_in,
  input  logic              beat_valid,
  input  logic [DATA_W-1:0] beat_data,
  output logic              fletcher_q,
  output logic [DATA_W-1:0] lo_next,
  output logic [DATA_W-1:0] hi_next
);
  ocsum_mode_e       mode_q;
  logic [DATA_W-1:0] lo_q;
  logic [DATA_W-1:0] hi_q;

  ocsum_add #(.DATA_W(DATA_W)) u_add_lo (.a(lo_q), .b(beat_data), .y(lo_next));
  ocsum_add #(.DATA_W(DATA_W)) u_add_hi (.a(hi_q), .b(lo_next),   .y(hi_next));

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MODE_SUM;
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (start) begin
      mode_q <= ocsum_mode_e'(mode_in);
      lo_q   <= '0;
      hi_q   <= '0;
    end else if (beat_valid) begin
      lo_q <= lo_next;
      if (mode_q == MODE_FLETCHER) begin
        hi_q <= hi_next;
      end
    end
  end

  assign fletcher_q = (mode_q == MODE_FLETCHER);

  AST_MODE_HELD: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(mode_q)); // R8
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!start && !beat_valid) |=> ($stable(lo_q) && $stable(hi_q))); // R9
  AST_PLAIN_HI_ZERO: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_SUM) |-> (hi_q == '0)); // R2
  AST_START_CLEARS: assert property (@(posedge clk) disable iff (rst)
    start |=> ((lo_q == '0) && (hi_q == '0))); // R5
endmodule

// File: rtl/ocsum_unit.sv
// Streaming ones'-complement / Fletcher checksum with reference compare.
module ocsum_unit #(
  parameter int DATA_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic                mode_sel,
  input  logic                in_valid,
  input  logic [DATA_W-1:0]   in_byte,
  input  logic                in_last,
  input  logic [2*DATA_W-1:0] ref_sum,
  output logic                done,
  output logic                mismatch,
  output logic [2*DATA_W-1:0] sum_out
);
  localparam int SUM_W = 2 * DATA_W;

  logic              fletcher_q;
  logic [DATA_W-1:0] lo_next;
  logic [DATA_W-1:0] hi_next;
  logic [SUM_W-1:0]  final_sum;
  logic              finish;

  ocsum_core #(.DATA_W(DATA_W)) u_core (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .mode_in    (mode_sel),
    .beat_valid (in_valid),
    .beat_data  (in_byte),
    .fletcher_q (fletcher_q),
    .lo_next    (lo_next),
    .hi_next    (hi_next)
  );

  assign finish    = in_valid && in_last;
  assign final_sum = {(fletcher_q ? hi_next : {DATA_W{1'b0}}), lo_next};

  always_ff @(posedge clk) begin
    if (rst) begin
      done     <= 1'b0;
      mismatch <= 1'b0;
      sum_out  <= '0;
    end else begin
      done <= finish;
      if (finish) begin
        sum_out  <= final_sum;
        mismatch <= (final_sum != ref_sum);
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R6
  AST_DONE_AFTER_LAST: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(in_valid && in_last)); // R6
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !finish |=> ($stable(sum_out) && $stable(mismatch))); // R6
  AST_MISMATCH_MEANS: assert property (@(posedge clk) disable iff (rst)
    done |-> (mismatch == (sum_out != $past(ref_sum)))); // R7
endmodule

// File: tb/test_ocsum_unit.sv
`timescale 1ns/1ps
module test_ocsum_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic        mode_sel = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = '0;
  logic        in_last = 1'b0;
  logic [15:0] ref_sum = '0;
  logic        done;
  logic        mismatch;
  logic [15:0] sum_out;

  int   n_checks = 0;
  int   n_errors = 0;
  bit   finished = 1'b0;
  logic [7:0] stim [64];

  always #4 clk = ~clk;

  ocsum_unit #(.DATA_W(8)) i_ocsum_unit (
    .clk(clk), .rst(rst), .start(start), .mode_sel(mode_sel),
    .in_valid(in_valid), .in_byte(in_byte), .in_last(in_last),
    .ref_sum(ref_sum), .done(done), .mismatch(mismatch), .sum_out(sum_out)
  );

  function automatic logic [7:0] oc_add8(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] t;
    t = {1'b0, a} + {1'b0, b};
    return t[8] ? (t[7:0] + 8'd1) : t[7:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic run_stream(input bit fl, input int n, input bit bad_ref,
                            input bit flip_mode, input bit bubbles, input string tag);
    logic [7:0]  ea = 8'h00;
    logic [7:0]  eb = 8'h00;
    logic [15:0] expv;
    logic [15:0] refv;
    for (int i = 0; i < n; i++) begin
      ea = oc_add8(ea, stim[i]);
      eb = oc_add8(eb, ea);
    end
    expv = fl ? {eb, ea} : {8'h00, ea};
    refv = bad_ref ? (expv ^ (16'h0001 << $urandom_range(15))) : expv;
    @(negedge clk);
    start = 1'b1; mode_sel = fl; in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk);
    start = 1'b0;
    if (flip_mode) mode_sel = !fl; // R8: must be ignored
    for (int i = 0; i < n; i++) begin
      if (bubbles && ($urandom_range(2) == 0)) begin
        in_valid = 1'b0; in_last = 1'b1; in_byte = 8'($urandom); ref_sum = ~refv;
        @(negedge clk);
        chk(done == 1'b0, "R9 bubble ends stream", {15'd0, done}, 16'd0);
      end
      in_valid = 1'b1; in_byte = stim[i]; in_last = (i == n - 1); ref_sum = refv;
      @(negedge clk);
      if (i != n - 1) chk(done == 1'b0, "R6 early done", {15'd0, done}, 16'd0);
    end
    in_valid = 1'b0; in_last = 1'b0; ref_sum = ~refv; in_byte = 8'($urandom);
    chk(done == 1'b1, "R6 done after last", {15'd0, done}, 16'd1);
    chk(sum_out == expv, tag, sum_out, expv);
    chk(mismatch == bad_ref, "R7 mismatch", {15'd0, mismatch}, {15'd0, bad_ref});
    @(negedge clk);
    chk(done == 1'b0, "R6 done single cycle", {15'd0, done}, 16'd0);
    chk(sum_out == expv, "R6 result held", sum_out, expv);
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(done == 1'b0 && mismatch == 1'b0, "R1 reset flags", {14'd0, done, mismatch}, 16'd0);
    chk(sum_out == 16'd0, "R1 reset sum", sum_out, 16'd0);

    stim[0] = 8'hFF; stim[1] = 8'h01;
    run_stream(1'b0, 2, 1'b0, 1'b0, 1'b0, "R3 FF+01 wraps");
    stim[0] = 8'h80; stim[1] = 8'h80;
    run_stream(1'b0, 2, 1'b0, 1'b0, 1'b0, "R3 80+80 wraps");
    stim[0] = 8'hFF; stim[1] = 8'hFF;
    run_stream(1'b1, 2, 1'b0, 1'b0, 1'b0, "R3 R4 fletcher FF FF");
    stim[0] = 8'h5A;
    run_stream(1'b1, 1, 1'b1, 1'b0, 1'b0, "R4 single byte");
    for (int i = 0; i < 8; i++) stim[i] = 8'hF0 + 8'(i);
    run_stream(1'b1, 8, 1'b0, 1'b1, 1'b0, "R8 fletcher with mode flip");
    run_stream(1'b0, 8, 1'b0, 1'b1, 1'b0, "R8 R5 plain with mode flip");

    for (int k = 0; k < 24; k++) begin
      int n = $urandom_range(40, 1);
      for (int i = 0; i < n; i++) stim[i] = 8'($urandom);
      run_stream(1'($urandom), n, 1'($urandom), 1'($urandom), 1'b1, "R2 R4 R5 random stream");
    end

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule